// File: doc/BRIEF.md
# Dual-Clock 8-bit Timer with Host Synchronizers

This block is an 8-bit up-counter clocked from a slow, free-running timer clock (nominally 32.768 kHz). A host reaches it from a much faster system clock. Host writes to the control, count and compare registers are held in the system domain. A toggle handshake carries each one into the timer domain, and a per-register busy bit tells software when the transfer has landed. Waiting for a busy bit to clear is therefore a way to be sure that a full timer period has passed.

The live count is seen by the host only through a holding register in the system domain. That register reloads on each rising edge of the timer clock. If the system clock is stopped for sleep and restarted while the timer clock is low, the held value stays as it was until the next timer rising edge. Compare-match and wrap events are registered once in the timer domain, then cross as toggles into sticky flags that the host clears by writing ones. The same registered events drive a wake request to a sleep controller. A compare output pin is driven straight from timer-domain flops.

Top module: `async_timer`

## Requirements
- R1: A host write (`host_wr` high for one system cycle) to address 0 (control), 1 (count) or 2 (compare) sets `busy` bit 0, 1 or 2 respectively on the next system edge. A busy bit never rises without such a write.
- R2: A busy bit stays set through the first two timer rising edges after the write. It clears within three system cycles after the third, when the written value takes effect in the timer domain.
- R3: A write to a register whose busy bit is set is discarded, and the value from the earlier write is the one loaded.
- R4: `cnt_rd` reloads from the counter only after a rising timer clock edge, within three system cycles. If the system clock stops and restarts while the timer clock is low, `cnt_rd` keeps its pre-sleep value until the next rising timer edge.
- R5: While control bit 0 (run) is set, the counter adds one on each timer edge that has no count load, and wraps from 255 to 0. Each wrap raises flag bit 1.
- R6: When an increment makes the counter equal to the compare register, flag bit 0 is raised. Loading the count does not raise it.
- R7: A flag becomes visible no earlier than three system cycles after the timer edge that follows the event. By then `cnt_rd` already shows the counter one past the value that caused the event.
- R8: `wake_req` is high for the timer cycle that starts one timer edge after a match or wrap, and low otherwise.
- R9: A write to address 3 clears each flag whose data bit is 1 (bit 0 match, bit 1 wrap). Data bits that are 0 leave their flag untouched.
- R10: Control bits [2:1] select the pin mode. 00 and 11 hold `cmp_out` low. 01 toggles it on each match. 10 drives it high when the control value is loaded and low on a match. Loading any other mode resets the pin flop to 0.
- R11: After reset, `cnt_rd`, `busy`, `irq_flags`, `wake_req` and `cmp_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Host/system clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst | input | 1 | Synchronous active-high reset, timer domain |
| host_wr | input | 1 | Write strobe, one system cycle per write |
| host_addr | input | 2 | 0 control, 1 count, 2 compare, 3 flag clear |
| host_wdata | input | 8 | Write data |
| cnt_rd | output | 8 | Held copy of the counter, system domain |
| busy | output | 3 | Update-pending bits: 0 control, 1 count, 2 compare |
| irq_flags | output | 2 | Sticky flags: bit 0 match, bit 1 wrap |
| wake_req | output | 1 | Wake request, timer domain |
| cmp_out | output | 1 | Compare output pin, timer domain |

## Verification
The assertions assume the timer clock is many system cycles slower than the system clock. This keeps the multi-bit count steady while the holding register samples it. They also assume each host write is a single-cycle strobe that is sampled cleanly at a system edge. The stimulus holds the timer clock at ten system cycles high and ten low, and drives every host input on falling system edges. The system clock is gated only while its raw source is low and the timer clock is low, so the sleep sequence never produces a runt pulse.

// File: rtl/async_timer_pkg.sv
package async_timer_pkg;

    localparam int CTRL_W     = 3;
    localparam int NUM_FLAGS  = 2;
    localparam int NUM_REGS   = 3;
    localparam int FLAG_MATCH = 0;
    localparam int FLAG_WRAP  = 1;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_COUNT   = 2'd1,
        REG_COMPARE = 2'd2,
        REG_FLAGS   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PIN_OFF    = 2'd0,
        PIN_TOGGLE = 2'd1,
        PIN_CLEAR  = 2'd2,
        PIN_RSVD   = 2'd3
    } pin_mode_e;

    // bit 0 run, bits [2:1] pin mode
    typedef struct packed {
        pin_mode_e mode;
        logic      run;
    } ctrl_t;

    function automatic logic pin_drives(input pin_mode_e m);
        return (m == PIN_TOGGLE) || (m == PIN_CLEAR);
    endfunction

    function automatic logic pin_after_match(input pin_mode_e m, input logic cur);
        case (m)
            PIN_TOGGLE: return ~cur;
            PIN_CLEAR:  return 1'b0;
            default:    return cur;
        endcase
    endfunction

    function automatic logic pin_after_load(input pin_mode_e m);
        return m == PIN_CLEAR;
    endfunction

endpackage

// File: rtl/async_timer_xfer.sv
module async_timer_xfer #(
    parameter int W = 8
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    output logic         busy,
    input  logic         tmr_clk,
    input  logic         tmr_rst,
    output logic         load,
    output logic [W-1:0] load_data
);

    logic         req_q;
    logic [W-1:0] data_q;
    logic         ack_s1, ack_s2;
    logic         req_s1, req_s2;
    logic         ack_q;

    assign busy      = req_q ^ ack_s2;
    assign load      = req_s2 ^ ack_q;
    assign load_data = data_q;

    // system side: capture value, flip request, watch acknowledge
    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            req_q  <= 1'b0;
            data_q <= '0;
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= ack_q;
            ack_s2 <= ack_s1;
            if (wr && !busy) begin
                req_q  <= ~req_q;
                data_q <= wr_data;
            end
        end
    end

    // timer side: two-flop request synchronizer, acknowledge on load
    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            req_s1 <= req_q;
            req_s2 <= req_s1;
            if (load) ack_q <= req_s2;
        end
    end

endmodule

// File: rtl/async_timer_core.sv
module async_timer_core
    import async_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 tmr_clk,
    input  logic                 tmr_rst,
    input  logic                 ld_ctrl,
    input  logic [CTRL_W-1:0]    ctrl_d,
    input  logic                 ld_cnt,
    input  logic [W-1:0]         cnt_d,
    input  logic                 ld_cmp,
    input  logic [W-1:0]         cmp_d,
    output logic [W-1:0]         cnt_q,
    output logic [W-1:0]         cmp_q,
    output ctrl_t                ctrl_q,
    output logic [NUM_FLAGS-1:0] evt_tgl,
    output logic                 wake,
    output logic                 pin
);

    logic                 step;
    logic [W-1:0]         cnt_nxt;
    logic [NUM_FLAGS-1:0] hit;
    logic [NUM_FLAGS-1:0] pend;
    logic                 pin_q;

    always_comb begin
        step            = ctrl_q.run && !ld_cnt;
        cnt_nxt         = cnt_q + 1'b1;
        hit             = '0;
        hit[FLAG_MATCH] = step && (cnt_nxt == cmp_q);
        hit[FLAG_WRAP]  = step && (&cnt_q);
    end

    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) begin
            cnt_q   <= '0;
            cmp_q   <= '0;
            ctrl_q  <= '0;
            pend    <= '0;
            evt_tgl <= '0;
            wake    <= 1'b0;
            pin_q   <= 1'b0;
        end else begin
            if (ld_cnt)    cnt_q <= cnt_d;
            else if (step) cnt_q <= cnt_nxt;
            if (ld_cmp)    cmp_q <= cmp_d;
            if (ld_ctrl)   ctrl_q <= ctrl_t'(ctrl_d);

            // events are registered once, then published a timer cycle later
            pend    <= hit;
            evt_tgl <= evt_tgl ^ pend;
            wake    <= |pend;

            if (ld_ctrl)
                pin_q <= pin_after_load(pin_mode_e'(ctrl_d[CTRL_W-1:1]));
            else if (hit[FLAG_MATCH])
                pin_q <= pin_after_match(ctrl_q.mode, pin_q);
        end
    end

    assign pin = pin_drives(ctrl_q.mode) ? pin_q : 1'b0;

endmodule

// File: rtl/async_timer_evsync.sv
module async_timer_evsync (
    input  logic sys_clk,
    input  logic sys_rst,
    input  logic evt_tgl,
    input  logic clr,
    output logic flag,
    output logic set
);

    logic s1, s2, s3;

    assign set = s2 ^ s3;

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            s3   <= 1'b0;
            flag <= 1'b0;
        end else begin
            s1   <= evt_tgl;
            s2   <= s1;
            s3   <= s2;
            flag <= set | (flag & ~clr);
        end
    end

endmodule

// File: rtl/async_timer_rdhold.sv
module async_timer_rdhold #(
    parameter int W = 8
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  logic         tmr_clk,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] hold
);

    logic c1, c2, c3;
    logic capture;

    // count only moves on a timer rising edge, so it is steady when the rise is seen here
    assign capture = c2 & ~c3;

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            c1   <= 1'b0;
            c2   <= 1'b0;
            c3   <= 1'b0;
            hold <= '0;
        end else begin
            c1 <= tmr_clk;
            c2 <= c1;
            c3 <= c2;
            if (capture) hold <= cnt;
        end
    end

endmodule

// File: rtl/async_timer.sv
module async_timer
    import async_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 sys_clk,
    input  logic                 sys_rst,
    input  logic                 tmr_clk,
    input  logic                 tmr_rst,
    input  logic                 host_wr,
    input  logic [1:0]           host_addr,
    input  logic [W-1:0]         host_wdata,
    output logic [W-1:0]         cnt_rd,
    output logic [NUM_REGS-1:0]  busy,
    output logic [NUM_FLAGS-1:0] irq_flags,
    output logic                 wake_req,
    output logic                 cmp_out
);

    logic                 ld_ctrl, ld_cnt, ld_cmp;
    logic [CTRL_W-1:0]    ctrl_d;
    logic [W-1:0]         cnt_d, cmp_d;
    logic [W-1:0]         cnt_q, cmp_q;
    ctrl_t                ctrl_q;
    logic [NUM_FLAGS-1:0] evt_tgl;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_set;

    assign flag_clr = (host_wr && host_addr == REG_FLAGS) ? host_wdata[NUM_FLAGS-1:0] : '0;

    async_timer_xfer #(.W(CTRL_W)) u_xfer_ctrl (
        .sys_clk  (sys_clk),
        .sys_rst  (sys_rst),
        .wr       (host_wr && host_addr == REG_CTRL),
        .wr_data  (host_wdata[CTRL_W-1:0]),
        .busy     (busy[REG_CTRL]),
        .tmr_clk  (tmr_clk),
        .tmr_rst  (tmr_rst),
        .load     (ld_ctrl),
        .load_data(ctrl_d)
    );

    async_timer_xfer #(.W(W)) u_xfer_cnt (
        .sys_clk  (sys_clk),
        .sys_rst  (sys_rst),
        .wr       (host_wr && host_addr == REG_COUNT),
        .wr_data  (host_wdata),
        .busy     (busy[REG_COUNT]),
        .tmr_clk  (tmr_clk),
        .tmr_rst  (tmr_rst),
        .load     (ld_cnt),
        .load_data(cnt_d)
    );

    async_timer_xfer #(.W(W)) u_xfer_cmp (
        .sys_clk  (sys_clk),
        .sys_rst  (sys_rst),
        .wr       (host_wr && host_addr == REG_COMPARE),
        .wr_data  (host_wdata),
        .busy     (busy[REG_COMPARE]),
        .tmr_clk  (tmr_clk),
        .tmr_rst  (tmr_rst),
        .load     (ld_cmp),
        .load_data(cmp_d)
    );

    async_timer_core #(.W(W)) u_core (
        .tmr_clk(tmr_clk),
        .tmr_rst(tmr_rst),
        .ld_ctrl(ld_ctrl),
        .ctrl_d (ctrl_d),
        .ld_cnt (ld_cnt),
        .cnt_d  (cnt_d),
        .ld_cmp (ld_cmp),
        .cmp_d  (cmp_d),
        .cnt_q  (cnt_q),
        .cmp_q  (cmp_q),
        .ctrl_q (ctrl_q),
        .evt_tgl(evt_tgl),
        .wake   (wake_req),
        .pin    (cmp_out)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        async_timer_evsync u_evsync (
            .sys_clk(sys_clk),
            .sys_rst(sys_rst),
            .evt_tgl(evt_tgl[g]),
            .clr    (flag_clr[g]),
            .flag   (irq_flags[g]),
            .set    (flag_set[g])
        );
    end

    async_timer_rdhold #(.W(W)) u_rdhold (
        .sys_clk(sys_clk),
        .sys_rst(sys_rst),
        .tmr_clk(tmr_clk),
        .cnt    (cnt_q),
        .hold   (cnt_rd)
    );

endmodule

// File: rtl/async_timer_chk.sv
module async_timer_chk #(
    parameter int W = 8
) (
    input logic         sys_clk,
    input logic         sys_rst,
    input logic         tmr_clk,
    input logic         tmr_rst,
    input logic         host_wr,
    input logic [1:0]   host_addr,
    input logic [1:0]   clr_bits,
    input logic [2:0]   busy,
    input logic [1:0]   irq_flags,
    input logic [1:0]   flag_set,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] cmp_q,
    input logic         run,
    input logic         ld_cnt,
    input logic         ld_ctrl,
    input logic         wake_req,
    input logic         cmp_out
);

    logic match_now;
    assign match_now = run && !ld_cnt && (W'(cnt_q + 1'b1) == cmp_q);

    for (genvar i = 0; i < 3; i++) begin : g_busy
        AST_BUSY_RAISE: assert property (@(posedge sys_clk) disable iff (sys_rst)
            (host_wr && host_addr == 2'(i) && !busy[i]) |=> busy[i]); // R1
        AST_BUSY_QUIET: assert property (@(posedge sys_clk) disable iff (sys_rst)
            (!busy[i] && !(host_wr && host_addr == 2'(i))) |=> !busy[i]); // R1
    end

    for (genvar f = 0; f < 2; f++) begin : g_flag
        AST_FLAG_CLEAR: assert property (@(posedge sys_clk) disable iff (sys_rst)
            (host_wr && host_addr == 2'd3 && clr_bits[f] && !flag_set[f]) |=> !irq_flags[f]); // R9
    end

    AST_COUNT_STEP: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        (run && !ld_cnt) |=> (cnt_q == W'($past(cnt_q) + 1'b1))); // R5

    AST_COUNT_WRAP: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        (run && !ld_cnt && (&cnt_q)) |=> (cnt_q == '0)); // R5

    AST_WAKE_AFTER: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        match_now |=> ##1 wake_req); // R8

    AST_PIN_STILL: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        (!ld_ctrl && !match_now) |=> $stable(cmp_out)); // R10

endmodule

bind async_timer async_timer_chk #(.W(W)) u_chk (
    .sys_clk  (sys_clk),
    .sys_rst  (sys_rst),
    .tmr_clk  (tmr_clk),
    .tmr_rst  (tmr_rst),
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .clr_bits (host_wdata[1:0]),
    .busy     (busy),
    .irq_flags(irq_flags),
    .flag_set (flag_set),
    .cnt_q    (cnt_q),
    .cmp_q    (cmp_q),
    .run      (ctrl_q.run),
    .ld_cnt   (ld_cnt),
    .ld_ctrl  (ld_ctrl),
    .wake_req (wake_req),
    .cmp_out  (cmp_out)
);

// File: tb/async_timer_bench.sv
module async_timer_bench;

    localparam int W = 8;

    logic raw_clk = 1'b0;
    logic sys_run = 1'b1;
    logic sys_clk;
    logic tmr_clk = 1'b0;
    logic sys_rst = 1'b1;
    logic tmr_rst = 1'b1;
    logic host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [W-1:0] host_wdata = '0;
    logic [W-1:0] cnt_rd;
    logic [2:0] busy;
    logic [1:0] irq_flags;
    logic wake_req;
    logic cmp_out;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 raw_clk = ~raw_clk;
    assign sys_clk = raw_clk & sys_run;

    async_timer #(.W(W)) u_async_timer (
        .sys_clk   (sys_clk),
        .sys_rst   (sys_rst),
        .tmr_clk   (tmr_clk),
        .tmr_rst   (tmr_rst),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .cnt_rd    (cnt_rd),
        .busy      (busy),
        .irq_flags (irq_flags),
        .wake_req  (wake_req),
        .cmp_out   (cmp_out)
    );

    // each entry: preset count, compare value, running timer edges
    localparam logic [23:0] VEC [6] = '{
        24'h10_14_06,
        24'hFC_50_08,
        24'hFE_00_05,
        24'h30_34_04,
        24'h80_10_03,
        24'hFF_AA_01
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge sys_clk);
        host_wr = 1'b1;
        host_addr = a;
        host_wdata = d;
        @(negedge sys_clk);
        host_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int t = 0; t < n; t++) begin
            @(negedge sys_clk);
            tmr_clk = 1'b1;
            repeat (10) @(negedge sys_clk);
            tmr_clk = 1'b0;
            repeat (9) @(negedge sys_clk);
        end
    endtask

    // expected {wrap, match, count} after k running edges from preset d
    function automatic logic [9:0] model(input logic [7:0] d, input logic [7:0] c, input int k);
        logic m = 1'b0;
        logic o = 1'b0;
        for (int j = 1; j < k; j++) begin
            int v = int'(d) + j;
            if (v[7:0] == c) m = 1'b1;
            if (v == 256) o = 1'b1;
        end
        return {o, m, 8'(int'(d) + k)};
    endfunction

    initial begin
        tick(3);
        @(negedge sys_clk);
        sys_rst = 1'b0;
        tmr_rst = 1'b0;
        idle(2);
        chk("R11 cnt_rd", cnt_rd, 0);
        chk("R11 busy", busy, 0);
        chk("R11 flags", irq_flags, 0);
        chk("R11 wake", wake_req, 0);
        chk("R11 pin", cmp_out, 0);

        for (int i = 0; i < 6; i++) begin
            logic [7:0] d = VEC[i][23:16];
            logic [7:0] c = VEC[i][15:8];
            int k = int'(VEC[i][7:0]);
            logic [9:0] e = model(d, c, k);
            wr(2'd0, 8'h00);
            wr(2'd1, d);
            wr(2'd2, c);
            chk("R1 busy all set", busy, 3'b111);
            tick(3);
            chk("R2 busy cleared", busy, 0);
            chk("R2 count loaded", cnt_rd, d);
            wr(2'd3, 8'h03);
            idle(1);
            chk("R9 flags cleared", irq_flags, 0);
            wr(2'd0, 8'h01);
            tick(3);
            tick(k);
            idle(2);
            chk("R5 count", cnt_rd, e[7:0]);
            chk("R6 match flag", irq_flags[0], e[8]);
            chk("R5 wrap flag", irq_flags[1], e[9]);
        end

        // latency of flag, wake and readback around one match
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h41);
        wr(2'd2, 8'h42);
        tick(3);
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h03);
        tick(3);
        chk("R10 toggle start", cmp_out, 0);
        tick(1);
        chk("R10 toggle on match", cmp_out, 1);
        chk("R8 wake not yet", wake_req, 0);
        chk("R7 flag not yet", irq_flags[0], 0);
        @(negedge sys_clk);
        tmr_clk = 1'b1;
        @(negedge sys_clk);
        chk("R8 wake raised", wake_req, 1);
        chk("R7 flag held off", irq_flags[0], 0);
        repeat (3) @(negedge sys_clk);
        chk("R7 flag visible", irq_flags[0], 1);
        chk("R7 count advanced", cnt_rd, 8'h43);
        repeat (6) @(negedge sys_clk);
        tmr_clk = 1'b0;
        repeat (9) @(negedge sys_clk);
        tick(1);
        chk("R8 wake dropped", wake_req, 0);
        wr(2'd3, 8'h02);
        idle(1);
        chk("R9 zero bit keeps flag", irq_flags[0], 1);
        wr(2'd3, 8'h01);
        idle(1);
        chk("R9 one bit clears flag", irq_flags[0], 0);

        // clear-on-match and reserved pin modes
        wr(2'd0, 8'h04);
        wr(2'd1, 8'h60);
        wr(2'd2, 8'h61);
        tick(3);
        chk("R10 clear mode load high", cmp_out, 1);
        wr(2'd0, 8'h05);
        tick(3);
        chk("R10 clear mode running", cmp_out, 1);
        tick(1);
        chk("R10 clear on match", cmp_out, 0);
        wr(2'd0, 8'h06);
        tick(3);
        chk("R10 reserved mode low", cmp_out, 0);

        // write while busy is discarded
        wr(2'd1, 8'h10);
        wr(2'd1, 8'h99);
        chk("R3 busy during transfer", busy[1], 1);
        tick(2);
        chk("R2 busy after two edges", busy[1], 1);
        tick(1);
        chk("R2 busy after third edge", busy[1], 0);
        chk("R3 first value kept", cnt_rd, 8'h10);

        // system clock stopped across timer edges
        wr(2'd1, 8'h20);
        wr(2'd0, 8'h01);
        tick(3);
        chk("R4 before sleep", cnt_rd, 8'h20);
        @(negedge raw_clk);
        sys_run = 1'b0;
        for (int s = 0; s < 2; s++) begin
            #100 tmr_clk = 1'b1;
            #100 tmr_clk = 1'b0;
        end
        #50;
        @(negedge raw_clk);
        sys_run = 1'b1;
        idle(6);
        chk("R4 stale after wake", cnt_rd, 8'h20);
        tick(1);
        chk("R4 refreshed on edge", cnt_rd, 8'h23);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge raw_clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule